// File: doc/BRIEF.md
# Register Exchange and Transfer Unit

This block carries out the combined register swap / register copy instruction of a small 8-bit processor core. It owns the programmer-visible register set: two accumulator bytes that pair into a 16-bit accumulator, four 16-bit pointer registers, the program counter and the direct-page byte. A start strobe presents an opcode and a one-byte postbyte. The unit then either exchanges two registers or copies one into another. It spends a fixed number of execution cycles on the operation and then pulses done.

The postbyte carries two 3-bit register selectors, and its top bit picks the operation. Both opcodes of the instruction pair run the same operation. The selector for the byte-B / 16-bit-D slot is asymmetric: it reads as the full 16-bit pair and writes only the low byte. A test port lets a bench preload any register and observe all of them. Instruction fetch, flags, the ALU and the bus are handled elsewhere.

Top module: `xfer_unit`

## Requirements
- R1: A start is accepted only when the unit is idle and the opcode is 0x3E or 0x3F. Both opcodes perform the same operation, and opcode bit 0 has no effect. A start with any other opcode is ignored: busy stays low and no register changes.
- R2: Postbyte bit 7 = 0 selects a swap and bit 7 = 1 selects a copy. The first selector is postbyte bits 2:0 and is the copy source. The second selector is bits 6:4 and is the copy destination. Bit 3 has no effect.
- R3: Selector codes are 0 = A, 1 = D on read / B on write, 2 = X, 3 = Y, 4 = DP, 5 = U, 6 = S, 7 = PC. The 16-bit registers are read and written whole.
- R4: Reading code 1 yields {A,B}. Writing code 1 loads the low byte of the value into B and leaves A unchanged.
- R5: Code 4 reads as zero. A write to code 4 is dropped, and DP keeps its value.
- R6: Code 0 reads as A zero-extended to 16 bits. A write to code 0 loads the low byte of the value into A.
- R7: A swap reads both registers before it writes either one. It first writes the old second value into the first register, then the old first value into the second. A swap of a register with itself therefore leaves it unchanged.
- R8: With the default parameters, done rises 2 clock edges after the accepting edge for a copy and 3 for a swap. Busy is high in every cycle between.
- R9: Done is high for exactly one cycle, and busy is low in that cycle.
- R10: The register results, including a write to PC, are visible on the register outputs in the cycle that done is high.
- R11: A start while busy is ignored. The running operation completes with its own operands and its own timing.
- R12: After reset all registers read zero and busy and done are low. While idle, tp_wr loads tp_data into the register chosen by tp_idx: 0 = A, 1 = B, 2 = X, 3 = Y, 4 = DP, 5 = U, 6 = S, 7 = PC. The byte registers take the low byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Start strobe for one instruction |
| opcode | input | 8 | Instruction opcode, sampled with start |
| postbyte | input | 8 | Operation bit and two register selectors, sampled with start |
| busy | output | 1 | High while an instruction executes |
| done | output | 1 | One-cycle completion pulse |
| tp_wr | input | 1 | Test-port register load strobe, honoured when idle |
| tp_idx | input | 3 | Test-port register index |
| tp_data | input | 2*DW | Test-port load value |
| reg_a | output | DW | Accumulator A |
| reg_b | output | DW | Accumulator B |
| reg_x | output | 2*DW | Pointer X |
| reg_y | output | 2*DW | Pointer Y |
| reg_dp | output | DW | Direct-page byte |
| reg_u | output | 2*DW | Pointer U |
| reg_s | output | 2*DW | Pointer S |
| reg_pc | output | 2*DW | Program counter |

## Verification
The bench builds the unit with its defaults: 8-bit bytes, two cycles for a copy and three for a swap. These are the values under which the cycle counts of R8 are stated, so each operation's done edge can be counted against a fixed figure. The byte width of 8 places the B-only write and the zero extension of A at a concrete byte boundary. Preload values with distinct high and low bytes make a wrong half or a wrong register show up on the outputs.

// File: rtl/xfer_pkg.sv
package xfer_pkg;
  typedef enum logic [2:0] {
    RC_A  = 3'd0,
    RC_DB = 3'd1,
    RC_X  = 3'd2,
    RC_Y  = 3'd3,
    RC_DP = 3'd4,
    RC_U  = 3'd5,
    RC_S  = 3'd6,
    RC_PC = 3'd7
  } rcode_e;

  typedef enum logic {
    OP_SWAP = 1'b0,
    OP_COPY = 1'b1
  } op_e;

  // both opcodes of the pair share bits 7:1
  localparam logic [6:0] OPC_XFER_HI = 7'h1F;
endpackage

// File: rtl/xfer_rdmux.sv
module xfer_rdmux #(
  parameter int DW = 8
) (
  input  logic [2:0]      code,
  input  logic [DW-1:0]   a,
  input  logic [DW-1:0]   b,
  input  logic [2*DW-1:0] x,
  input  logic [2*DW-1:0] y,
  input  logic [2*DW-1:0] u,
  input  logic [2*DW-1:0] s,
  input  logic [2*DW-1:0] pc,
  output logic [2*DW-1:0] val
);
  import xfer_pkg::*;
  localparam int WW = 2 * DW;

  always_comb begin
    unique case (rcode_e'(code))
      RC_A:    val = {{DW{1'b0}}, a};
      RC_DB:   val = {a, b};
      RC_X:    val = x;
      RC_Y:    val = y;
      RC_DP:   val = '0;
      RC_U:    val = u;
      RC_S:    val = s;
      RC_PC:   val = pc;
      default: val = {WW{1'b0}};
    endcase
  end
endmodule

// File: rtl/xfer_regs.sv
module xfer_regs #(
  parameter int DW = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  xfer_pkg::rcode_e      wr_code,
  input  logic [2*DW-1:0]       wr_data,
  input  logic                  tp_wr,
  input  logic [2:0]            tp_idx,
  input  logic [2*DW-1:0]       tp_data,
  output logic [DW-1:0]         a_q,
  output logic [DW-1:0]         b_q,
  output logic [2*DW-1:0]       x_q,
  output logic [2*DW-1:0]       y_q,
  output logic [DW-1:0]         dp_q,
  output logic [2*DW-1:0]       u_q,
  output logic [2*DW-1:0]       s_q,
  output logic [2*DW-1:0]       pc_q
);
  import xfer_pkg::*;

  logic [DW-1:0]   a_n, b_n, dp_n;
  logic [2*DW-1:0] x_n, y_n, u_n, s_n, pc_n;

  always_comb begin
    a_n  = a_q;
    b_n  = b_q;
    dp_n = dp_q;
    x_n  = x_q;
    y_n  = y_q;
    u_n  = u_q;
    s_n  = s_q;
    pc_n = pc_q;
    if (wr_en) begin
      unique case (wr_code)
        RC_A:  a_n  = wr_data[DW-1:0];
        RC_DB: b_n  = wr_data[DW-1:0];
        RC_X:  x_n  = wr_data;
        RC_Y:  y_n  = wr_data;
        RC_DP: ;
        RC_U:  u_n  = wr_data;
        RC_S:  s_n  = wr_data;
        RC_PC: pc_n = wr_data;
        default: ;
      endcase
    end else if (tp_wr) begin
      unique case (tp_idx)
        3'd0: a_n  = tp_data[DW-1:0];
        3'd1: b_n  = tp_data[DW-1:0];
        3'd2: x_n  = tp_data;
        3'd3: y_n  = tp_data;
        3'd4: dp_n = tp_data[DW-1:0];
        3'd5: u_n  = tp_data;
        3'd6: s_n  = tp_data;
        3'd7: pc_n = tp_data;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q  <= '0;
      b_q  <= '0;
      dp_q <= '0;
      x_q  <= '0;
      y_q  <= '0;
      u_q  <= '0;
      s_q  <= '0;
      pc_q <= '0;
    end else if (wr_en || tp_wr) begin
      a_q  <= a_n;
      b_q  <= b_n;
      dp_q <= dp_n;
      x_q  <= x_n;
      y_q  <= y_n;
      u_q  <= u_n;
      s_q  <= s_n;
      pc_q <= pc_n;
    end
  end

  // only the test port may change the direct-page byte
  assert_dp_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !tp_wr |=> $stable(dp_q));

  // a write through the D/B code never disturbs A
  assert_b_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_code == RC_DB) |=> $stable(a_q));
endmodule

// File: rtl/xfer_seq.sv
module xfer_seq #(
  parameter int DW       = 8,
  parameter int COPY_CYC = 2,
  parameter int SWAP_CYC = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [7:0]            opcode,
  input  logic [7:0]            postbyte,
  input  logic [2*DW-1:0]       rd_first,
  input  logic [2*DW-1:0]       rd_second,
  output logic                  busy,
  output logic                  done,
  output logic                  wr_en,
  output xfer_pkg::rcode_e      wr_code,
  output logic [2*DW-1:0]       wr_data
);
  import xfer_pkg::*;

  localparam int MAXC = (SWAP_CYC > COPY_CYC) ? SWAP_CYC : COPY_CYC;
  localparam int CW   = $clog2(MAXC) + 1;
  localparam logic [CW-1:0] LAST_CP = CW'(COPY_CYC - 1);
  localparam logic [CW-1:0] LAST_SW = CW'(SWAP_CYC - 1);
  localparam logic [CW-1:0] PEN_SW  = CW'(SWAP_CYC - 2);

  logic            busy_q, busy_n;
  logic            done_q, done_n;
  logic [CW-1:0]   cnt_q, cnt_n;
  op_e             op_q;
  rcode_e          c1_q, c2_q;
  logic [2*DW-1:0] v1_q, v2_q;
  logic            accept;
  logic [CW-1:0]   last;

  assign accept = start && !busy_q && (opcode[7:1] == OPC_XFER_HI);
  assign last   = (op_q == OP_COPY) ? LAST_CP : LAST_SW;

  // write schedule: swap writes the first register one cycle before the end
  always_comb begin
    wr_en   = 1'b0;
    wr_code = c2_q;
    wr_data = v1_q;
    if (busy_q) begin
      if (cnt_q == last) begin
        wr_en = 1'b1;
      end else if (op_q == OP_SWAP && cnt_q == PEN_SW) begin
        wr_en   = 1'b1;
        wr_code = c1_q;
        wr_data = v2_q;
      end
    end
  end

  always_comb begin
    busy_n = busy_q;
    done_n = 1'b0;
    cnt_n  = cnt_q;
    if (accept) begin
      busy_n = 1'b1;
      cnt_n  = '0;
    end else if (busy_q) begin
      if (cnt_q == last) begin
        busy_n = 1'b0;
        done_n = 1'b1;
      end else begin
        cnt_n = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_n;
      done_q <= done_n;
      cnt_q  <= cnt_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q <= OP_SWAP;
      c1_q <= RC_A;
      c2_q <= RC_A;
      v1_q <= '0;
      v2_q <= '0;
    end else if (accept) begin
      op_q <= op_e'(postbyte[7]);
      c1_q <= rcode_e'(postbyte[2:0]);
      c2_q <= rcode_e'(postbyte[6:4]);
      v1_q <= rd_first;
      v2_q <= rd_second;
    end
  end

  assign busy = busy_q;
  assign done = done_q;

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !busy_q);

  assert_cnt_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (cnt_q <= last));

  assert_wr_in_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> busy_q);

  assert_busy_ignores_start_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && cnt_q != last) |=> (busy_q && $stable(op_q) && $stable(v1_q)));
endmodule

// File: rtl/xfer_unit.sv
module xfer_unit #(
  parameter int DW       = 8,
  parameter int COPY_CYC = 2,
  parameter int SWAP_CYC = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [7:0]        opcode,
  input  logic [7:0]        postbyte,
  output logic              busy,
  output logic              done,
  input  logic              tp_wr,
  input  logic [2:0]        tp_idx,
  input  logic [2*DW-1:0]   tp_data,
  output logic [DW-1:0]     reg_a,
  output logic [DW-1:0]     reg_b,
  output logic [2*DW-1:0]   reg_x,
  output logic [2*DW-1:0]   reg_y,
  output logic [DW-1:0]     reg_dp,
  output logic [2*DW-1:0]   reg_u,
  output logic [2*DW-1:0]   reg_s,
  output logic [2*DW-1:0]   reg_pc
);
  import xfer_pkg::*;
  localparam int WW    = 2 * DW;
  localparam int NSEL  = 2;

  logic          rst_meta, rst_sync;
  logic [2:0]    sel_code [NSEL];
  logic [WW-1:0] sel_val  [NSEL];
  logic          wr_en;
  rcode_e        wr_code;
  logic [WW-1:0] wr_data;
  logic          tp_wr_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  assign sel_code[0] = postbyte[2:0];
  assign sel_code[1] = postbyte[6:4];

  for (genvar g = 0; g < NSEL; g++) begin : g_rd
    xfer_rdmux #(.DW(DW)) u_rd (
      .code (sel_code[g]),
      .a    (reg_a),
      .b    (reg_b),
      .x    (reg_x),
      .y    (reg_y),
      .u    (reg_u),
      .s    (reg_s),
      .pc   (reg_pc),
      .val  (sel_val[g])
    );
  end

  xfer_seq #(.DW(DW), .COPY_CYC(COPY_CYC), .SWAP_CYC(SWAP_CYC)) u_seq (
    .clk       (clk),
    .rst_n     (rst_sync),
    .start     (start),
    .opcode    (opcode),
    .postbyte  (postbyte),
    .rd_first  (sel_val[0]),
    .rd_second (sel_val[1]),
    .busy      (busy),
    .done      (done),
    .wr_en     (wr_en),
    .wr_code   (wr_code),
    .wr_data   (wr_data)
  );

  assign tp_wr_ok = tp_wr && !busy;

  xfer_regs #(.DW(DW)) u_regs (
    .clk     (clk),
    .rst_n   (rst_sync),
    .wr_en   (wr_en),
    .wr_code (wr_code),
    .wr_data (wr_data),
    .tp_wr   (tp_wr_ok),
    .tp_idx  (tp_idx),
    .tp_data (tp_data),
    .a_q     (reg_a),
    .b_q     (reg_b),
    .x_q     (reg_x),
    .y_q     (reg_y),
    .dp_q    (reg_dp),
    .u_q     (reg_u),
    .s_q     (reg_s),
    .pc_q    (reg_pc)
  );

  // a start with a foreign opcode never raises busy
  assert_foreign_opcode_R1: assert property (@(posedge clk) disable iff (!rst_sync)
    (!busy && start && opcode[7:1] != OPC_XFER_HI) |=> !busy);
endmodule

// File: tb/tb_xfer_unit.sv
module tb_xfer_unit;
  localparam int DW = 8;
  localparam int WW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [7:0]    opcode = 8'h00;
  logic [7:0]    postbyte = 8'h00;
  logic          busy, done;
  logic          tp_wr = 1'b0;
  logic [2:0]    tp_idx = 3'd0;
  logic [WW-1:0] tp_data = '0;
  logic [DW-1:0] reg_a, reg_b, reg_dp;
  logic [WW-1:0] reg_x, reg_y, reg_u, reg_s, reg_pc;

  int total = 0;
  int bad   = 0;
  logic [WW-1:0] m [8];

  always #4 clk = ~clk;

  xfer_unit dut (
    .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode), .postbyte(postbyte),
    .busy(busy), .done(done), .tp_wr(tp_wr), .tp_idx(tp_idx), .tp_data(tp_data),
    .reg_a(reg_a), .reg_b(reg_b), .reg_x(reg_x), .reg_y(reg_y), .reg_dp(reg_dp),
    .reg_u(reg_u), .reg_s(reg_s), .reg_pc(reg_pc)
  );

  task automatic check(input string req, input logic [WW-1:0] act, input logic [WW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // model indices follow the test-port index: A,B,X,Y,DP,U,S,PC
  function automatic logic [WW-1:0] mrd(input int code);
    case (code)
      0: return {8'h00, m[0][7:0]};
      1: return {m[0][7:0], m[1][7:0]};
      4: return '0;
      default: return m[code];
    endcase
  endfunction

  task automatic mwr(input int code, input logic [WW-1:0] v);
    case (code)
      0: m[0] = {8'h00, v[7:0]};
      1: m[1] = {8'h00, v[7:0]};
      4: ;
      default: m[code] = v;
    endcase
  endtask

  task automatic compare_all(input string req);
    check({req, " A"},  {8'h00, reg_a},  m[0]);
    check({req, " B"},  {8'h00, reg_b},  m[1]);
    check({req, " X"},  reg_x,  m[2]);
    check({req, " Y"},  reg_y,  m[3]);
    check({req, " DP"}, {8'h00, reg_dp}, m[4]);
    check({req, " U"},  reg_u,  m[5]);
    check({req, " S"},  reg_s,  m[6]);
    check({req, " PC"}, reg_pc, m[7]);
  endtask

  task automatic tp_load(input int idx, input logic [WW-1:0] v);
    @(negedge clk);
    tp_wr = 1'b1; tp_idx = 3'(idx); tp_data = v;
    @(negedge clk);
    tp_wr = 1'b0;
    if (idx == 0 || idx == 1 || idx == 4) m[idx] = {8'h00, v[7:0]};
    else m[idx] = v;
  endtask

  task automatic preload();
    tp_load(0, 16'h0011);
    tp_load(1, 16'h0022);
    tp_load(2, 16'h1234);
    tp_load(3, 16'h5678);
    tp_load(4, 16'h0099);
    tp_load(5, 16'h9ABC);
    tp_load(6, 16'hDEF0);
    tp_load(7, 16'h4321);
  endtask

  // runs one instruction; with 'poke' a second start is held during busy (R11)
  task automatic run_op(input string req, input logic [7:0] opc, input logic [7:0] pb, input bit poke);
    logic [WW-1:0] v1, v2;
    int c1, c2, n, cyc;
    c1 = int'(pb[2:0]);
    c2 = int'(pb[6:4]);
    v1 = mrd(c1);
    v2 = mrd(c2);
    if (pb[7]) begin
      mwr(c2, v1); n = 2;
    end else begin
      mwr(c1, v2); mwr(c2, v1); n = 3;
    end
    @(negedge clk);
    start = 1'b1; opcode = opc; postbyte = pb;
    @(negedge clk);
    if (poke) postbyte = 8'hA2;
    else start = 1'b0;
    check({req, " R8 busy after start"}, {15'd0, busy}, 16'd1);
    cyc = 0;
    do begin
      @(negedge clk);
      start = 1'b0;
      cyc++;
    end while (!done && cyc < 20);
    check({req, " R8 cycles to done"}, 16'(cyc), 16'(n));
    check({req, " R9 busy low at done"}, {15'd0, busy}, 16'd0);
    compare_all({req, " R10"});
    @(negedge clk);
    check({req, " R9 done one cycle"}, {15'd0, done}, 16'd0);
  endtask

  task automatic t_reset();
    compare_all("R12 reset");
    check("R12 busy reset", {15'd0, busy}, 16'd0);
    check("R12 done reset", {15'd0, done}, 16'd0);
  endtask

  task automatic t_opcodes();
    preload();
    run_op("R1 R2 R3 copy X->Y 3E", 8'h3E, 8'hB2, 1'b0);
    tp_load(2, 16'hAAAA);
    run_op("R1 copy X->Y 3F", 8'h3F, 8'hB2, 1'b0);
    tp_load(2, 16'h0F0F);
    run_op("R2 bit3 ignored", 8'h3E, 8'hBA, 1'b0);
    run_op("R1 swap via 3F", 8'h3F, 8'h23, 1'b0);
    @(negedge clk);
    start = 1'b1; opcode = 8'h12; postbyte = 8'hB2;
    @(negedge clk);
    start = 1'b0;
    check("R1 foreign opcode no busy", {15'd0, busy}, 16'd0);
    @(negedge clk);
    compare_all("R1 foreign opcode regs");
  endtask

  task automatic t_swap();
    preload();
    run_op("R7 swap U,S", 8'h3E, 8'h65, 1'b0);
    run_op("R7 swap A,D", 8'h3E, 8'h10, 1'b0);
    check("R7 A took old B", {8'h00, reg_a}, 16'h0022);
    run_op("R7 swap X,X", 8'h3E, 8'h22, 1'b0);
  endtask

  task automatic t_db();
    preload();
    run_op("R4 copy D->X", 8'h3E, 8'hA1, 1'b0);
    check("R4 X holds A:B", reg_x, 16'h1122);
    tp_load(2, 16'h7E5D);
    run_op("R4 copy X->B", 8'h3E, 8'h92, 1'b0);
    check("R4 B low byte", {8'h00, reg_b}, 16'h005D);
    check("R4 A kept", {8'h00, reg_a}, 16'h0011);
    run_op("R4 copy D->D", 8'h3E, 8'h91, 1'b0);
  endtask

  task automatic t_dp_a();
    preload();
    run_op("R5 copy X->DP", 8'h3E, 8'hC2, 1'b0);
    check("R5 DP unchanged", {8'h00, reg_dp}, 16'h0099);
    run_op("R5 copy DP->Y", 8'h3E, 8'hB4, 1'b0);
    check("R5 DP reads zero", reg_y, 16'h0000);
    run_op("R6 copy X->A", 8'h3E, 8'h82, 1'b0);
    check("R6 A low byte", {8'h00, reg_a}, 16'h0034);
    run_op("R6 copy A->U", 8'h3E, 8'hD0, 1'b0);
    check("R6 A zero-extended", reg_u, 16'h0034);
  endtask

  task automatic t_pc_busy();
    preload();
    run_op("R10 copy X->PC", 8'h3E, 8'hF2, 1'b0);
    check("R10 PC at done", reg_pc, 16'h1234);
    run_op("R11 start held while busy", 8'h3E, 8'h65, 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    for (int i = 0; i < 8; i++) m[i] = '0;
    t_reset();
    t_opcodes();
    t_swap();
    t_db();
    t_dp_a();
    t_pc_busy();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #800000;
    total++;
    bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule